// File: doc/BRIEF.md
# Clock Ratio Meter with Reference-Loss Detection

This block measures how many cycles of a fast local clock fit into each period of a slower, asynchronous reference clock. The reference is brought into the fast domain through a flop chain. Each rising edge it sees closes one period and opens the next. At the close of each period, the block subtracts a programmed target ratio from the cycle count. It then publishes the signed error together with a single-cycle valid strobe, which a downstream frequency tuner consumes.

A second path watches for a reference that has stopped or become far too slow. If no reference edge arrives for longer than twice the largest programmable ratio, the block raises a sticky loss flag. It can also raise an interrupt pulse when that flag rises. When the reference comes back, the flag drops by itself and measurement resumes. The first period after reset, after enable or after recovery is always partial, so the block never publishes it.

Top module: `clk_ratio_meter`

## Requirements
- R1: When a period closes, `diff_o` holds the number of fast-clock cycles between two successive synchronised reference rising edges, minus `ratio_i`. The value is a two's-complement number one bit wider than `ratio_i`, so a count below the ratio gives a negative value.
- R2: The period count saturates at 2^CNT_W-1 and never wraps. A longer period reports 2^CNT_W-1 minus `ratio_i`.
- R3: `diff_vld_o` pulses high for exactly one cycle for each period that closes while measurement is armed.
- R4: The period that ends at the first reference edge after reset, after `meas_en_i` rises, or after recovery from loss is discarded and produces no strobe.
- R5: `ref_lost_o` rises when no synchronised reference edge has been seen for 2*(2^CNT_W-1)+1 fast cycles. It stays low for any shorter gap.
- R6: A reference edge clears `ref_lost_o`. Strobes then resume from the next complete period.
- R7: `lost_irq_o` is a one-cycle pulse in the cycle `ref_lost_o` goes from 0 to 1, provided `lost_irq_en_i` is 1. It does not pulse at any other time.
- R8: `diff_vld_o` never asserts while `ref_lost_o` is set.
- R9: While `meas_en_i` is 0, no strobe is produced and `ref_lost_o` and `lost_irq_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock being measured |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Asynchronous reference clock |
| meas_en_i | input | 1 | Measurement enable |
| ratio_i | input | CNT_W | Target fast cycles per reference period |
| lost_irq_en_i | input | 1 | Enable for the loss interrupt |
| diff_o | output | CNT_W+1 | Signed count minus ratio |
| diff_vld_o | output | 1 | One-cycle strobe for a new `diff_o` |
| ref_lost_o | output | 1 | Reference stopped or too slow |
| lost_irq_o | output | 1 | Pulse on rising loss flag |

## Verification
Errors in the period counter or the arming flag show up at the port within one reference period. They appear as a wrong `diff_o` value, or as a strobe that is missing or extra on the next edge. A stop timer that is off by a few cycles only shows up after about 2*(2^CNT_W-1) fast cycles of silence. For that reason the bench samples the loss flag just before and just after that bound. A faulty interrupt edge detector shows up as a pulse count other than one per loss event, checked with the enable both on and off.

// File: rtl/crm_pkg.sv
package crm_pkg;
  localparam int unsigned SYNC_MIN = 2;

  // Fast cycles without a reference edge before the reference counts as lost
  function automatic int unsigned stop_limit(input int unsigned cnt_w);
    return 2 * ((1 << cnt_w) - 1);
  endfunction
endpackage

// File: rtl/crm_rst_sync.sv
module crm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/crm_ref_sync.sv
module crm_ref_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_clk_i,
  output logic rise_o
);
  logic [STAGES:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q[0] <= 1'b0;
    else         ff_q[0] <= ref_clk_i;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q[g] <= 1'b0;
      else         ff_q[g] <= ff_q[g-1];
    end
  end

  // ff_q[STAGES] is the delayed copy used only for edge detection
  assign rise_o = ff_q[STAGES-1] & ~ff_q[STAGES];
endmodule

// File: rtl/crm_period_cnt.sv
module crm_period_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rise_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)                cnt_d = '0;
    else if (rise_i)          cnt_d = CNT_W'(1);
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/crm_stop_watch.sv
module crm_stop_watch #(
  parameter int unsigned CNT_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rise_i,
  input  logic irq_en_i,
  output logic lost_o,
  output logic irq_o
);
  import crm_pkg::*;

  localparam int unsigned LIMIT = stop_limit(CNT_W);
  localparam int unsigned TMR_W = $clog2(LIMIT + 1);
  localparam logic [TMR_W-1:0] LAST = TMR_W'(LIMIT - 1);

  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             lost_q, lost_d;
  logic             irq_q, irq_d;

  always_comb begin
    tmr_d = tmr_q;
    if (!en_i || rise_i)  tmr_d = '0;
    else if (tmr_q != LAST) tmr_d = tmr_q + TMR_W'(1);

    lost_d = en_i & ~rise_i & (lost_q | (tmr_q == LAST));
    irq_d  = lost_d & ~lost_q & irq_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      lost_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      tmr_q  <= tmr_d;
      lost_q <= lost_d;
      irq_q  <= irq_d;
    end
  end

  assign lost_o = lost_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/clk_ratio_meter.sv
module clk_ratio_meter #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SYNC_STGS = crm_pkg::SYNC_MIN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_clk_i,
  input  logic             meas_en_i,
  input  logic [CNT_W-1:0] ratio_i,
  input  logic             lost_irq_en_i,
  output logic [CNT_W:0]   diff_o,
  output logic             diff_vld_o,
  output logic             ref_lost_o,
  output logic             lost_irq_o
);
  localparam int unsigned DIFF_W = CNT_W + 1;

  logic             rst_sn;
  logic             rise;
  logic [CNT_W-1:0] count;
  logic             lost;

  logic              armed_q, armed_d;
  logic [DIFF_W-1:0] diff_q, diff_d;
  logic              vld_q, vld_d;
  logic              publish;

  crm_rst_sync #(.STAGES(SYNC_STGS)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_sn)
  );

  crm_ref_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_sn),
    .ref_clk_i(ref_clk_i),
    .rise_o   (rise)
  );

  crm_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_sn),
    .en_i   (meas_en_i),
    .rise_i (rise),
    .count_o(count)
  );

  crm_stop_watch #(.CNT_W(CNT_W)) u_stop (
    .clk_i   (clk_i),
    .rst_ni  (rst_sn),
    .en_i    (meas_en_i),
    .rise_i  (rise),
    .irq_en_i(lost_irq_en_i),
    .lost_o  (lost),
    .irq_o   (lost_irq_o)
  );

  assign publish = meas_en_i & rise & armed_q & ~lost;

  always_comb begin
    armed_d = armed_q;
    if (!meas_en_i || lost) armed_d = 1'b0;
    if (meas_en_i && rise)  armed_d = 1'b1;

    diff_d = diff_q;
    if (publish) diff_d = {1'b0, count} - {1'b0, ratio_i};
    vld_d = publish;
  end

  always_ff @(posedge clk_i or negedge rst_sn) begin
    if (!rst_sn) begin
      armed_q <= 1'b0;
      diff_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      diff_q  <= diff_d;
      vld_q   <= vld_d;
    end
  end

  assign diff_o     = diff_q;
  assign diff_vld_o = vld_q;
  assign ref_lost_o = lost;
endmodule

// File: rtl/crm_checker.sv
module crm_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic meas_en_i,
  input logic lost_irq_en_i,
  input logic diff_vld_o,
  input logic ref_lost_o,
  input logic lost_irq_o
);
  AST_VLD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diff_vld_o |=> !diff_vld_o); // R3

  AST_NO_VLD_WHILE_LOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diff_vld_o |-> !ref_lost_o); // R8

  AST_IRQ_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_irq_o |-> (ref_lost_o && !$past(ref_lost_o) && $past(lost_irq_en_i))); // R7

  AST_RISE_GIVES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ref_lost_o) && $past(lost_irq_en_i)) |-> lost_irq_o); // R7

  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(meas_en_i) |-> (!diff_vld_o && !ref_lost_o && !lost_irq_o)); // R9
endmodule

bind clk_ratio_meter crm_checker chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .meas_en_i    (meas_en_i),
  .lost_irq_en_i(lost_irq_en_i),
  .diff_vld_o   (diff_vld_o),
  .ref_lost_o   (ref_lost_o),
  .lost_irq_o   (lost_irq_o)
);

// File: tb/clk_ratio_meter_tb_top.sv
`timescale 1ns/1ps
module clk_ratio_meter_tb_top;
  localparam int W    = 8;
  localparam int SMAX = (1 << W) - 1;
  localparam int LIM  = 2 * SMAX;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ref_clk = 1'b0;
  logic         meas_en = 1'b0;
  logic [W-1:0] ratio = '0;
  logic         irq_en = 1'b0;
  logic [W:0]   diff;
  logic         vld, lost, irq;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  int expq[$];
  logic prev_vld = 1'b0;

  always #10 clk = ~clk;

  clk_ratio_meter #(.CNT_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .meas_en_i(meas_en),
    .ratio_i(ratio), .lost_irq_en_i(irq_en), .diff_o(diff), .diff_vld_o(vld),
    .ref_lost_o(lost), .lost_irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: n rising edges spaced per cycles; pushes expected results
  task automatic ref_edges(input int n, input int per, input bit expect_out);
    for (int i = 0; i < n; i++) begin
      ref_clk = 1'b1;
      if (i > 0 && expect_out)
        expq.push_back(((per > SMAX) ? SMAX : per) - int'(ratio)); // R1 R2, first discarded R4
      wait_cyc(per / 2);
      ref_clk = 1'b0;
      wait_cyc(per - per / 2);
    end
  endtask

  task automatic rearm();
    meas_en = 1'b0;
    wait_cyc(3);
    meas_en = 1'b1;
    wait_cyc(3);
  endtask

  task automatic drain(input string req);
    wait_cyc(10);
    check(req, expq.size(), 0);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (vld) begin
        if (prev_vld) check("R3 strobe width", 2, 1);
        if (expq.size() == 0) check("R3/R4 unexpected strobe", 1, 0);
        else check("R1 diff value", int'($signed(diff)), expq.pop_front());
      end
      if (irq) irq_cnt++;
      prev_vld = vld;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    check("R3 reset vld", int'(vld), 0);
    check("R5 reset lost", int'(lost), 0);
    check("R7 reset irq", int'(irq), 0);
    check("R1 reset diff", int'(diff), 0);

    // R1 R4: zero error, positive, negative
    ratio = 8'd50; rearm(); ref_edges(5, 50, 1); drain("R4 zero error");
    ratio = 8'd50; rearm(); ref_edges(4, 64, 1); drain("R1 positive");
    ratio = 8'd50; rearm(); ref_edges(4, 40, 1); drain("R1 negative");
    // R2: exact max and saturation
    ratio = 8'd0;   rearm(); ref_edges(3, 255, 1); drain("R2 at max");
    ratio = 8'd200; rearm(); ref_edges(3, 300, 1); drain("R2 saturate");

    // R9: disabled, reference running then stopped
    meas_en = 1'b0; irq_en = 1'b1;
    ref_edges(3, 30, 0);
    wait_cyc(700);
    check("R9 lost while disabled", int'(lost), 0);
    check("R9 irq while disabled", irq_cnt, 0);
    drain("R9 no strobe");

    // R5 R7 R8: loss with interrupt enabled
    ratio = 8'd20; rearm(); ref_edges(3, 20, 1);
    wait_cyc(LIM - 40);
    check("R5 lost too early", int'(lost), 0);
    wait_cyc(50);
    check("R5 lost set", int'(lost), 1);
    check("R7 one irq", irq_cnt, 1);
    wait_cyc(300);
    check("R7 no repeat irq", irq_cnt, 1);
    drain("R8 no strobe while lost");

    // R6: recovery, first period discarded
    ratio = 8'd25; ref_edges(4, 30, 1);
    check("R6 lost cleared", int'(lost), 0);
    drain("R6 resume");

    // R7: loss with interrupt disabled
    irq_en = 1'b0;
    wait_cyc(LIM + 50);
    check("R5 lost again", int'(lost), 1);
    check("R7 masked irq", irq_cnt, 1);
    ref_edges(2, 30, 1);
    check("R6 cleared again", int'(lost), 0);
    drain("R6 final");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule